// File: doc/BRIEF.md
# Switchable Y-Memory Address Decoder

This block sorts each access to the 16-bit Y data space into one of three kinds: internal Y RAM, a reserved window that has been handed over to program memory, or external memory. The boundary between internal and reserved space moves with two fields of an operating-mode word. The word is sampled on every clock, and the decoder uses the value from the previous edge.

The lowest part of the Y space is a shared region that a filter coprocessor can reach as well as the core. The block flags core accesses that land in this region. It gives the coprocessor a select for the region and refuses DMA requests into it. It raises a same-cycle flag when the core and the coprocessor touch the same 256-word bank of the shared region. A sticky bit keeps that conflict until software-side logic clears it. A core access to a reserved address drives no select. It produces a one-cycle error pulse on the following clock.

Top module: `ymem_decoder`

## Requirements
- R1: After reset the mode is unswitched, and `core_rsv_err` and `conflict_sticky` are 0. `mode_word` is registered on every rising edge, and the decode in a cycle uses the value captured at the previous edge, not the current input.
- R2: When the registered `mode_word[7]` is 0, a requested address below 0xC000 is internal and an address at or above 0xC000 is external. Nothing is reserved in this mode.
- R3: When the registered `mode_word[7]` is 1, the internal space ends below a boundary set by `mode_word[1:0]`: 00 gives 0x4000, 01 gives 0x6000, 10 gives 0x8000 and 11 gives 0xA000. Addresses from the boundary up to 0xBFFF are reserved, and addresses from 0xC000 up are external. The other bits of `mode_word` have no effect.
- R4: A core request to a reserved address asserts neither `core_int_sel` nor `core_ext_sel`. `core_rsv_err` is high for exactly the cycle after each such request, and it is low after any other cycle.
- R5: `core_shared` is high exactly when the core requests an address below 0x2800. Such an access is also internal (`core_int_sel` high).
- R6: `cop_sel` is high exactly when the coprocessor requests an address below 0x2800. It is low for coprocessor addresses outside the shared region.
- R7: A DMA request below 0x2800 raises `dma_deny` and no select. Other DMA requests decode like core requests: internal, external, or neither for a reserved address, with `dma_deny` low.
- R8: `bank_conflict` is high in the same cycle when both the core and the coprocessor request shared-region addresses whose bits [15:8] are equal.
- R9: `conflict_sticky` becomes 1 on the edge after any cycle with `bank_conflict` high. It returns to 0 on an edge where `conflict_clr` is high and no conflict is present. A conflict takes priority over a clear in the same cycle.
- R10: With no request on a port, all outputs of that port are 0 whatever its address, and `bank_conflict` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_word | input | 8 | Operating-mode word; bit 7 switch enable, bits 1:0 switch configuration |
| core_req | input | 1 | Core access valid |
| core_addr | input | 16 | Core Y address |
| cop_req | input | 1 | Coprocessor access valid |
| cop_addr | input | 16 | Coprocessor Y address |
| dma_req | input | 1 | DMA access valid |
| dma_addr | input | 16 | DMA Y address |
| conflict_clr | input | 1 | Clears the sticky conflict bit |
| core_int_sel | output | 1 | Core access goes to internal Y RAM |
| core_ext_sel | output | 1 | Core access goes to external memory |
| core_shared | output | 1 | Core access is in the shared region |
| core_rsv_err | output | 1 | Registered pulse after a core access to reserved space |
| cop_sel | output | 1 | Coprocessor access to the shared region |
| dma_int_sel | output | 1 | DMA access goes to internal Y RAM |
| dma_ext_sel | output | 1 | DMA access goes to external memory |
| dma_deny | output | 1 | DMA request into the shared region refused |
| bank_conflict | output | 1 | Core and coprocessor in the same shared bank this cycle |
| conflict_sticky | output | 1 | Latched bank conflict |

## Verification
The assertions assume that the inputs change only between clock edges. They also assume that every address is a full 16-bit value with no unknown bits while its request is high. The bench drives all inputs one time unit after each rising edge and never leaves a field at X. It compares the outputs on the falling edge. The random stimulus covers every mode, including mode changes in the middle of traffic. Coprocessor addresses are drawn near the core address often, so that same-bank conflicts, adjacent-bank near misses and conflicts next to a clear all occur.

// File: rtl/ymem_decoder.sv
module ymem_decoder #(
  parameter int AW         = 16,
  parameter int MW         = 8,
  parameter int EN_BIT     = 7,
  parameter int BANK_LSB   = 8,
  parameter logic [15:0] SHARED_END = 16'h2800,
  parameter logic [15:0] EXT_BASE   = 16'hC000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] mode_word,
  input  logic          core_req,
  input  logic [AW-1:0] core_addr,
  input  logic          cop_req,
  input  logic [AW-1:0] cop_addr,
  input  logic          dma_req,
  input  logic [AW-1:0] dma_addr,
  input  logic          conflict_clr,
  output logic          core_int_sel,
  output logic          core_ext_sel,
  output logic          core_shared,
  output logic          core_rsv_err,
  output logic          cop_sel,
  output logic          dma_int_sel,
  output logic          dma_ext_sel,
  output logic          dma_deny,
  output logic          bank_conflict,
  output logic          conflict_sticky
);

  localparam logic [AW-1:0] SH_END = AW'(SHARED_END);
  localparam logic [AW-1:0] X_BASE = AW'(EXT_BASE);

  logic          sw_en_q;
  logic [1:0]    sw_cfg_q;
  logic [AW-1:0] int_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_en_q  <= 1'b0;
      sw_cfg_q <= 2'b00;
    end else begin
      sw_en_q  <= mode_word[EN_BIT];
      sw_cfg_q <= mode_word[1:0];
    end
  end

  always_comb begin
    if (!sw_en_q) int_end = X_BASE;
    else begin
      case (sw_cfg_q)
        2'b00:   int_end = AW'(16'h4000);
        2'b01:   int_end = AW'(16'h6000);
        2'b10:   int_end = AW'(16'h8000);
        default: int_end = AW'(16'hA000);
      endcase
    end
  end

  logic core_is_int, core_is_ext, core_is_rsv, core_in_sh;
  logic dma_is_int, dma_is_ext, dma_in_sh;
  logic cop_in_sh;

  assign core_is_int = core_addr < int_end;
  assign core_is_ext = core_addr >= X_BASE;
  assign core_is_rsv = !core_is_int && !core_is_ext;
  assign core_in_sh  = core_addr < SH_END;

  assign dma_is_int  = dma_addr < int_end;
  assign dma_is_ext  = dma_addr >= X_BASE;
  assign dma_in_sh   = dma_addr < SH_END;

  assign cop_in_sh   = cop_addr < SH_END;

  assign core_int_sel = core_req && core_is_int;
  assign core_ext_sel = core_req && core_is_ext;
  assign core_shared  = core_req && core_in_sh;

  assign cop_sel      = cop_req && cop_in_sh;

  assign dma_deny     = dma_req && dma_in_sh;
  assign dma_int_sel  = dma_req && dma_is_int && !dma_in_sh;
  assign dma_ext_sel  = dma_req && dma_is_ext;

  assign bank_conflict = core_shared && cop_sel &&
                         (core_addr[AW-1:BANK_LSB] == cop_addr[AW-1:BANK_LSB]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_rsv_err    <= 1'b0;
      conflict_sticky <= 1'b0;
    end else begin
      core_rsv_err <= core_req && core_is_rsv;
      if (bank_conflict)     conflict_sticky <= 1'b1;
      else if (conflict_clr) conflict_sticky <= 1'b0;
    end
  end

endmodule

module ymem_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        core_req,
  input logic [15:0] core_addr,
  input logic        dma_req,
  input logic        conflict_clr,
  input logic        core_int_sel,
  input logic        core_ext_sel,
  input logic        core_shared,
  input logic        core_rsv_err,
  input logic        cop_sel,
  input logic        dma_int_sel,
  input logic        dma_ext_sel,
  input logic        dma_deny,
  input logic        bank_conflict,
  input logic        conflict_sticky
);

  // R2
  ext_above_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_ext_sel |-> core_addr >= 16'hC000);

  // R3
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_int_sel, core_ext_sel}));

  // R4
  rsv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && core_req && !core_int_sel && !core_ext_sel) |=> core_rsv_err);

  // R4
  rsv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rsv_err |-> $past(core_req && !core_int_sel && !core_ext_sel));

  // R5
  shared_is_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_shared |-> core_int_sel);

  // R7
  dma_deny_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_deny |-> (!dma_int_sel && !dma_ext_sel && dma_req));

  // R8
  conflict_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_conflict |-> (core_shared && cop_sel));

  // R9
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && bank_conflict) |=> conflict_sticky);

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && conflict_sticky && !conflict_clr) |=> conflict_sticky);

endmodule

bind ymem_decoder ymem_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_addr(core_addr),
  .dma_req(dma_req), .conflict_clr(conflict_clr),
  .core_int_sel(core_int_sel), .core_ext_sel(core_ext_sel),
  .core_shared(core_shared), .core_rsv_err(core_rsv_err), .cop_sel(cop_sel),
  .dma_int_sel(dma_int_sel), .dma_ext_sel(dma_ext_sel), .dma_deny(dma_deny),
  .bank_conflict(bank_conflict), .conflict_sticky(conflict_sticky)
);

// File: tb/ymem_decoder_test.sv
`timescale 1ns/100ps
module ymem_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  mode_word = '0;
  logic        core_req = 0, cop_req = 0, dma_req = 0, conflict_clr = 0;
  logic [15:0] core_addr = '0, cop_addr = '0, dma_addr = '0;
  logic core_int_sel, core_ext_sel, core_shared, core_rsv_err, cop_sel;
  logic dma_int_sel, dma_ext_sel, dma_deny, bank_conflict, conflict_sticky;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ymem_decoder uut (.*);

  // behavioural reference state
  bit m_en; int m_cfg; bit m_err; bit m_sticky;

  function automatic int limit_of(bit en, int cfg);
    if (!en) return 49152;
    case (cfg)
      0: return 16384;
      1: return 24576;
      2: return 32768;
      default: return 40960;
    endcase
  endfunction

  function automatic int kind_of(int a);
    int lim = limit_of(m_en, m_cfg);
    if (a >= 49152) return 2;
    if (a < lim) return 0;
    return 1;
  endfunction

  function automatic bit sh(int a); return a < 10240; endfunction

  function automatic bit conf_now();
    return core_req && cop_req && sh(core_addr) && sh(cop_addr) &&
           (core_addr / 256 == cop_addr / 256);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 0; m_cfg <= 0; m_err <= 0; m_sticky <= 0;
    end else begin
      m_err <= core_req && (kind_of(core_addr) == 1);
      if (conf_now()) m_sticky <= 1;
      else if (conflict_clr) m_sticky <= 0;
      m_en  <= mode_word[7];
      m_cfg <= mode_word[1:0];
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int ck = kind_of(core_addr);
    int dk = kind_of(dma_addr);
    string mt = m_en ? "R3" : "R2";
    chk({mt, " core_int_sel"}, core_int_sel, core_req && ck == 0);
    chk({mt, " core_ext_sel"}, core_ext_sel, core_req && ck == 2);
    chk("R4 core_rsv_err", core_rsv_err, m_err);
    chk("R5 core_shared", core_shared, core_req && sh(core_addr));
    chk("R6 cop_sel", cop_sel, cop_req && sh(cop_addr));
    chk("R7 dma_deny", dma_deny, dma_req && sh(dma_addr));
    chk("R7 dma_int_sel", dma_int_sel, dma_req && !sh(dma_addr) && dk == 0);
    chk("R7 dma_ext_sel", dma_ext_sel, dma_req && dk == 2);
    chk("R8 bank_conflict", bank_conflict, conf_now());
    chk("R9 conflict_sticky", conflict_sticky, m_sticky);
  endtask

  task automatic step(logic [7:0] mw, logic cr, logic [15:0] ca, logic pr,
                      logic [15:0] pa, logic dr, logic [15:0] da, logic clr);
    @(posedge clk); #1;
    mode_word = mw; core_req = cr; core_addr = ca; cop_req = pr; cop_addr = pa;
    dma_req = dr; dma_addr = da; conflict_clr = clr;
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  localparam logic [15:0] PTS [14] = '{16'h0000, 16'h27FF, 16'h2800, 16'h3FFF,
    16'h4000, 16'h5FFF, 16'h6000, 16'h7FFF, 16'h8000, 16'h9FFF, 16'hA000,
    16'hBFFF, 16'hC000, 16'hFFFF};

  initial begin
    core_req = 1; core_addr = 16'h5000; cop_req = 1; cop_addr = 16'h5000;
    mode_word = 8'h80;
    #12;
    // R1 reset state
    chk("R1 reset core_rsv_err", core_rsv_err, 1'b0);
    chk("R1 reset conflict_sticky", conflict_sticky, 1'b0);
    chk("R1 reset unswitched int", core_int_sel, 1'b1);
    @(negedge clk); rst_n = 1;

    // R1: new mode not visible in the cycle it is applied
    step(8'h00, 1, 16'h5000, 0, 0, 0, 0, 0);
    step(8'h80, 1, 16'h5000, 0, 0, 0, 0, 0);
    chk("R1 old mode still used", core_int_sel, 1'b1);
    step(8'h80, 1, 16'h5000, 0, 0, 0, 0, 0);
    chk("R1 new mode applied", core_int_sel, 1'b0);

    // R2/R3/R4/R7 sweeps over all modes, other mode bits toggled
    for (int m = 0; m < 5; m++) begin
      logic [7:0] mw = (m == 0) ? 8'h7C : {1'b1, 5'b10101, 2'(m - 1)};
      step(mw, 0, 0, 0, 0, 0, 0, 0);
      for (int i = 0; i < 14; i++)
        step(mw, 1, PTS[i], 0, 0, 1, PTS[13 - i], 0);
      step(mw, 0, 0, 0, 0, 0, 0, 0);
    end

    // R8/R9 directed conflicts
    step(8'h00, 1, 16'h1234, 1, 16'h12FF, 0, 0, 0);
    chk("R8 same bank", bank_conflict, 1'b1);
    step(8'h00, 1, 16'h1234, 1, 16'h1300, 0, 0, 0);
    chk("R8 adjacent bank", bank_conflict, 1'b0);
    chk("R9 sticky latched", conflict_sticky, 1'b1);
    step(8'h00, 1, 16'h2900, 1, 16'h2900, 0, 0, 1);
    chk("R8 outside shared", bank_conflict, 1'b0);
    step(8'h00, 1, 16'h0005, 1, 16'h0000, 0, 0, 1);
    chk("R9 cleared", conflict_sticky, 1'b0);
    step(8'h00, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 conflict beats clear", conflict_sticky, 1'b1);

    // R10 idle ports with busy addresses
    step(8'h80, 0, 16'h1000, 0, 16'h1000, 0, 16'h1000, 1);
    chk("R10 idle core", core_int_sel | core_shared | core_ext_sel, 1'b0);
    chk("R10 idle cop", cop_sel | bank_conflict, 1'b0);
    chk("R10 idle dma", dma_deny | dma_int_sel | dma_ext_sel, 1'b0);
    step(8'h80, 0, 16'h5000, 0, 0, 0, 0, 0);
    chk("R10 idle no rsv_err", core_rsv_err, 1'b0);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] ca = 16'($urandom);
      logic [15:0] pa;
      logic [7:0]  mw = (n % 37 == 0) ? 8'($urandom) : mode_word;
      if ($urandom_range(0, 2) == 0) ca = 16'($urandom_range(0, 16'h2FFF));
      case ($urandom_range(0, 2))
        0: pa = {ca[15:8], 8'($urandom)};
        1: pa = ca + 16'h0100;
        default: pa = 16'($urandom_range(0, 16'h2FFF));
      endcase
      step(mw, 1'($urandom), ca, 1'($urandom), pa, 1'($urandom),
           16'($urandom), ($urandom_range(0, 3) == 0));
    end
    finish_up();
  end
endmodule